// File: doc/BRIEF.md
# Memory Repair Signature Loader with Replay Cache

This controller delivers the repair signature of a set of memory groups into their serial repair registers every time the memories power up or change power state. Each load has three steps in a fixed order. First, one instruction is shifted into the wrapper of every group. Groups that hold repairable memories get the instruction that opens their repair chain, and all other groups get the bypass instruction. Second, the decoded signature is shifted into the repair chains. Third, every wrapper is returned to bypass, which puts the memories back into functional mode.

The first load after a global reset reads the one-time fuse array at two cycles per fuse bit and expands a run-length code. At the same time it copies the decoded bits into an internal serial cache that is as long as the repair chain. Every later load shifts the signature straight out of that cache. The cache output is fed back into its input, so the cached contents survive each replay. These loads skip the fuse read and the decoder, which saves the whole fuse access time.

Top module: `repair_sig_loader`

## Requirements
- R1: A `start` pulse accepted while idle raises `busy` in the next cycle. The wrapper select phase follows for N_GROUPS*INSTR_LEN cycles with `wir_shift` high. Then comes the signature phase. Then the bypass phase runs for N_GROUPS*INSTR_LEN cycles with `wir_shift` high. Last, `done` is high for exactly one cycle while `busy` is still high. `wir_shift` and `rc_shift` are never high together.
- R2: In the select phase, the wrapper stream on `wir_si` carries group N_GROUPS-1 first and group 0 last, each code least significant bit first. Group g receives RSC_CODE when bit g of REPAIRABLE is 1, and BYP_CODE otherwise.
- R3: In the bypass phase, every group receives BYP_CODE, in the same order and bit order as R2.
- R4: On a load that reads fuses, `fuse_rd` is high for one cycle with `fuse_addr` valid. `fuse_bit` is sampled at the end of the following cycle, with the address held. `fuse_rd` is never high in two consecutive cycles. Addresses count up from 0 with no gaps.
- R5: The fuse stream is read as a sequence of entries, and each entry starts with a flag bit. Flag 0 is followed by 8 literal bits, which are emitted in read order. Flag 1 is followed by a 4-bit count (least significant bit read first) and a value bit, and the value is emitted count+1 times. Decoding stops as soon as CHAIN_LEN bits have been produced, even in the middle of an entry, and no further fuse bit is read.
- R6: Every load drives exactly CHAIN_LEN bits on `rc_si`, each qualified by `rc_shift`, in decode order.
- R7: `cache_ok` is 0 after reset. It rises together with `done` at the end of the first load, and only `rst_n` clears it.
- R8: While `cache_ok` is 1, a load issues no `fuse_rd`. It shifts the same CHAIN_LEN bits as the fuse load, on consecutive cycles. The cycle that shows `done` is 2*N_GROUPS*INSTR_LEN+CHAIN_LEN clock edges after the edge that accepted `start`.
- R9: Repeated replays deliver the same signature each time.
- R10: A `start` pulse seen while `busy` is high is ignored. The load keeps its length and wrapper stream, `done` pulses once, and `busy` stays low afterwards.
- R11: During and right after reset, `busy`, `done`, `wir_shift`, `rc_shift`, `fuse_rd` and `cache_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| start | input | 1 | Pulse that requests one load |
| fuse_rd | output | 1 | Fuse read strobe |
| fuse_addr | output | $clog2(FUSE_DEPTH) | Fuse bit address |
| fuse_bit | input | 1 | Fuse data, valid in the cycle after the strobe |
| wir_shift | output | 1 | Wrapper instruction shift enable |
| wir_si | output | 1 | Wrapper instruction serial data |
| rc_shift | output | 1 | Repair chain shift enable |
| rc_si | output | 1 | Repair chain serial data |
| done | output | 1 | One-cycle pulse at the end of a load |
| busy | output | 1 | A load is in progress |
| cache_ok | output | 1 | The cache holds a valid signature |

## Verification
Faults in the phase counters show up as a wrong count of `wir_shift` or `rc_shift` cycles, or as a wrong total latency. A fault in the group order or code choice shows up in the first wrapper bits that reach the ports. A decoder that drifts by even one fuse bit corrupts `rc_si` right away and changes the `fuse_rd` count of the first load. A cache that fills, rotates or flags itself wrongly is exposed within one replay, by a stray fuse strobe, by a different signature, or by a second replay that differs from the first.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_SIG,
    PH_BYP,
    PH_DONE
  } rsl_phase_e;

  typedef enum logic [2:0] {
    DS_FLAG,
    DS_LIT,
    DS_CNT,
    DS_VAL,
    DS_RUN
  } rsl_dec_e;
endpackage

// File: rtl/rsl_fuse_decoder.sv
module rsl_fuse_decoder #(
  parameter int FA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  output logic            fuse_rd,
  output logic [FA_W-1:0] fuse_addr,
  input  logic            fuse_bit,
  output logic            out_valid,
  output logic            out_bit
);
  import rsl_pkg::*;

  rsl_dec_e        st_q, st_d;
  logic            rdph_q, rdph_d;
  logic [FA_W-1:0] addr_q, addr_d;
  logic [2:0]      bcnt_q, bcnt_d;
  logic [3:0]      run_q, run_d;
  logic            rval_q, rval_d;
  logic            cap;

  assign fuse_rd   = en && (st_q != DS_RUN) && !rdph_q;
  assign cap       = en && (st_q != DS_RUN) && rdph_q;
  assign fuse_addr = addr_q;
  assign out_valid = en && (((st_q == DS_LIT) && cap) || (st_q == DS_RUN));
  assign out_bit   = (st_q == DS_RUN) ? rval_q : fuse_bit;

  always_comb begin
    st_d   = st_q;
    rdph_d = rdph_q;
    addr_d = addr_q;
    bcnt_d = bcnt_q;
    run_d  = run_q;
    rval_d = rval_q;
    if (clr) begin
      st_d   = DS_FLAG;
      rdph_d = 1'b0;
      addr_d = '0;
      bcnt_d = '0;
      run_d  = '0;
    end else if (en) begin
      if (st_q == DS_RUN) begin
        if (run_q == 4'd0) st_d = DS_FLAG;
        else               run_d = run_q - 4'd1;
      end else if (!rdph_q) begin
        rdph_d = 1'b1;
      end else begin
        rdph_d = 1'b0;
        addr_d = addr_q + FA_W'(1);
        case (st_q)
          DS_FLAG: begin
            bcnt_d = '0;
            run_d  = '0;
            st_d   = fuse_bit ? DS_CNT : DS_LIT;
          end
          DS_LIT: begin
            bcnt_d = bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) st_d = DS_FLAG;
          end
          DS_CNT: begin
            run_d[bcnt_q[1:0]] = fuse_bit;
            bcnt_d = bcnt_q + 3'd1;
            if (bcnt_q == 3'd3) st_d = DS_VAL;
          end
          default: begin
            rval_d = fuse_bit;
            st_d   = DS_RUN;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DS_FLAG;
      rdph_q <= 1'b0;
      addr_q <= '0;
      bcnt_q <= '0;
      run_q  <= '0;
      rval_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rdph_q <= rdph_d;
      addr_q <= addr_d;
      bcnt_q <= bcnt_d;
      run_q  <= run_d;
      rval_q <= rval_d;
    end
  end

  // R4: each fuse bit takes a strobe cycle plus a capture cycle
  p_fuse_pace_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |=> !fuse_rd);
  // R4: the address is held while the strobed bit is captured
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_rd && !clr) |=> $stable(fuse_addr));
endmodule

// File: rtl/rsl_sig_cache.sv
module rsl_sig_cache #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic rotate,
  input  logic fill_bit,
  output logic out_bit
);
  logic [LEN-1:0] q_q, q_d;
  logic           din;

  assign out_bit = q_q[0];
  assign din     = rotate ? q_q[0] : fill_bit;

  generate
    if (LEN > 1) begin : g_long
      always_comb q_d = shift_en ? {din, q_q[LEN-1:1]} : q_q;
    end else begin : g_one
      always_comb q_d = shift_en ? din : q_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  // R9: replay rotation returns the serial output to the far end
  p_rotate_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && rotate) |=> (q_q[LEN-1] == $past(out_bit)));
endmodule

// File: rtl/rsl_instr_shifter.sv
module rsl_instr_shifter #(
  parameter int                     N_GROUPS   = 4,
  parameter int                     INSTR_LEN  = 22,
  parameter logic [N_GROUPS-1:0]    REPAIRABLE = '0,
  parameter logic [INSTR_LEN-1:0]   RSC_CODE   = '1,
  parameter logic [INSTR_LEN-1:0]   BYP_CODE   = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel_mode,
  output logic so,
  output logic last
);
  localparam int BW = $clog2(INSTR_LEN > 1 ? INSTR_LEN : 2);
  localparam int GW = $clog2(N_GROUPS > 1 ? N_GROUPS : 2);

  logic [BW-1:0]        b_q, b_d;
  logic [GW-1:0]        g_q, g_d;
  logic [GW-1:0]        grp;
  logic [INSTR_LEN-1:0] code;
  logic                 b_end;

  assign b_end = (b_q == BW'(INSTR_LEN - 1));
  assign last  = en && b_end && (g_q == GW'(N_GROUPS - 1));
  assign grp   = GW'(N_GROUPS - 1) - g_q;
  assign code  = (sel_mode && REPAIRABLE[grp]) ? RSC_CODE : BYP_CODE;
  assign so    = code[b_q];

  always_comb begin
    b_d = b_q;
    g_d = g_q;
    if (!en) begin
      b_d = '0;
      g_d = '0;
    end else if (b_end) begin
      b_d = '0;
      g_d = last ? '0 : g_q + GW'(1);
    end else begin
      b_d = b_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      g_q <= '0;
    end else begin
      b_q <= b_d;
      g_q <= g_d;
    end
  end

  // R1: a phase starts from the first bit of the first group
  p_phase_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (b_q == '0 && g_q == '0));
endmodule

// File: rtl/repair_sig_loader.sv
module repair_sig_loader #(
  parameter int                   N_GROUPS   = 4,
  parameter int                   INSTR_LEN  = 22,
  parameter int                   CHAIN_LEN  = 32,
  parameter int                   FUSE_DEPTH = 64,
  parameter logic [N_GROUPS-1:0]  REPAIRABLE = 4'b1010,
  parameter logic [INSTR_LEN-1:0] RSC_CODE   = 22'h2C5A3,
  parameter logic [INSTR_LEN-1:0] BYP_CODE   = 22'h3F00F,
  localparam int                  FA_W       = $clog2(FUSE_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            fuse_rd,
  output logic [FA_W-1:0] fuse_addr,
  input  logic            fuse_bit,
  output logic            wir_shift,
  output logic            wir_si,
  output logic            rc_shift,
  output logic            rc_si,
  output logic            done,
  output logic            busy,
  output logic            cache_ok
);
  import rsl_pkg::*;

  localparam int SW = $clog2(CHAIN_LEN + 1);

  rsl_phase_e    ph_q, ph_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          ok_q, ok_d;
  logic          instr_en, instr_last;
  logic          dec_en, dec_clr, dec_valid, dec_bit;
  logic          cache_out;

  assign instr_en  = (ph_q == PH_SEL) || (ph_q == PH_BYP);
  assign dec_en    = (ph_q == PH_SIG) && !ok_q;
  assign dec_clr   = (ph_q == PH_IDLE) && start;
  assign wir_shift = instr_en;
  assign rc_shift  = (ph_q == PH_SIG) && (ok_q || dec_valid);
  assign rc_si     = ok_q ? cache_out : dec_bit;
  assign done      = (ph_q == PH_DONE);
  assign busy      = (ph_q != PH_IDLE);
  assign cache_ok  = ok_q;

  rsl_instr_shifter #(
    .N_GROUPS(N_GROUPS), .INSTR_LEN(INSTR_LEN), .REPAIRABLE(REPAIRABLE),
    .RSC_CODE(RSC_CODE), .BYP_CODE(BYP_CODE)
  ) u_instr (
    .clk(clk), .rst_n(rst_n), .en(instr_en), .sel_mode(ph_q == PH_SEL),
    .so(wir_si), .last(instr_last)
  );

  rsl_fuse_decoder #(.FA_W(FA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .clr(dec_clr),
    .fuse_rd(fuse_rd), .fuse_addr(fuse_addr), .fuse_bit(fuse_bit),
    .out_valid(dec_valid), .out_bit(dec_bit)
  );

  rsl_sig_cache #(.LEN(CHAIN_LEN)) u_cache (
    .clk(clk), .rst_n(rst_n), .shift_en(rc_shift), .rotate(ok_q),
    .fill_bit(dec_bit), .out_bit(cache_out)
  );

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    ok_d  = ok_q;
    case (ph_q)
      PH_IDLE: if (start) ph_d = PH_SEL;
      PH_SEL: begin
        cnt_d = '0;
        if (instr_last) ph_d = PH_SIG;
      end
      PH_SIG: begin
        if (rc_shift) begin
          if (cnt_q == SW'(CHAIN_LEN - 1)) ph_d = PH_BYP;
          else                              cnt_d = cnt_q + SW'(1);
        end
      end
      PH_BYP: begin
        if (instr_last) begin
          ph_d = PH_DONE;
          ok_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: wrapper and repair chain shifting never overlap
  p_shift_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wir_shift && rc_shift));
  // R7: once valid, the cache flag stays set until reset
  p_cache_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cache_ok |=> cache_ok);
  // R8: a cached load leaves the fuses alone
  p_no_fuse_cached_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cache_ok |-> !fuse_rd);
  // R10: a start during a load does not restart the sequence
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/tb_repair_sig_loader.sv
module tb_repair_sig_loader;
  localparam int N   = 4;
  localparam int IL  = 22;
  localparam int L   = 32;
  localparam int FD  = 64;
  localparam int FAW = $clog2(FD);
  localparam logic [N-1:0]  REP = 4'b1010;
  localparam logic [IL-1:0] RSC = 22'h2C5A3;
  localparam logic [IL-1:0] BYP = 22'h3F00F;
  localparam int WTOT = 2 * N * IL;

  logic clk = 1'b0;
  logic rst_n, start;
  logic fuse_rd, fuse_bit, wir_shift, wir_si, rc_shift, rc_si, done, busy, cache_ok;
  logic [FAW-1:0] fuse_addr;
  logic fuse_mem [FD];
  logic exp_sig [L];
  int   f_idx, e_idx;
  int   checks = 0, errors = 0, wd = 0;
  int   n_cyc, n_wir, n_rc, n_fuse, n_done, wir_err, rc_err, addr_err, busy_err;

  always #10 clk = ~clk;

  assign fuse_bit = fuse_mem[fuse_addr];

  repair_sig_loader #(
    .N_GROUPS(N), .INSTR_LEN(IL), .CHAIN_LEN(L), .FUSE_DEPTH(FD),
    .REPAIRABLE(REP), .RSC_CODE(RSC), .BYP_CODE(BYP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fuse_rd(fuse_rd),
    .fuse_addr(fuse_addr), .fuse_bit(fuse_bit), .wir_shift(wir_shift),
    .wir_si(wir_si), .rc_shift(rc_shift), .rc_si(rc_si), .done(done),
    .busy(busy), .cache_ok(cache_ok)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_wir(input int k);
    bit sel = (k < N * IL);
    int kk = sel ? k : k - N * IL;
    int g  = N - 1 - kk / IL;
    logic [IL-1:0] code = (sel && REP[g]) ? RSC : BYP;
    return code[kk % IL];
  endfunction

  task automatic put_fuse(input logic b);
    fuse_mem[f_idx] = b;
    f_idx++;
  endtask

  task automatic put_exp(input logic b);
    if (e_idx < L) exp_sig[e_idx] = b;
    e_idx++;
  endtask

  task automatic put_lit(input logic [7:0] v);
    put_fuse(1'b0);
    for (int i = 7; i >= 0; i--) begin
      put_fuse(v[i]);
      put_exp(v[i]);
    end
  endtask

  task automatic put_run(input logic [3:0] c, input logic v);
    put_fuse(1'b1);
    for (int i = 0; i < 4; i++) put_fuse(c[i]);
    put_fuse(v);
    for (int i = 0; i <= int'(c); i++) put_exp(v);
  endtask

  task automatic run_load(input int inj_a, input int inj_b);
    n_cyc = 0; n_wir = 0; n_rc = 0; n_fuse = 0; n_done = 0;
    wir_err = 0; rc_err = 0; addr_err = 0; busy_err = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    while (1) begin
      start = (n_cyc == inj_a || n_cyc == inj_b);
      if (wir_shift) begin
        if (n_wir < WTOT && wir_si !== exp_wir(n_wir)) wir_err++;
        n_wir++;
      end
      if (rc_shift) begin
        if (n_rc < L && rc_si !== exp_sig[n_rc]) rc_err++;
        n_rc++;
      end
      if (fuse_rd) begin
        if (int'(fuse_addr) != n_fuse) addr_err++;
        n_fuse++;
      end
      if (!busy) busy_err++;
      if (done) begin
        n_done++;
        break;
      end
      n_cyc++;
      if (n_cyc > 5000) begin
        chk(1'b0, "watchdog", n_cyc, 0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wir_shift && !rc_shift && !fuse_rd && !cache_ok,
        "R11 outputs idle in reset", {busy, done, wir_shift, rc_shift, fuse_rd, cache_ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cache_ok, "R11 idle after reset", {busy, cache_ok}, 0);
  endtask

  task automatic t_fuse_load();
    run_load(-1, -1);
    chk(n_wir == WTOT, "R1 wrapper shift cycles", n_wir, WTOT);
    chk(wir_err == 0, "R2 R3 wrapper stream bits", wir_err, 0);
    chk(n_rc == L, "R6 chain bit count", n_rc, L);
    chk(rc_err == 0, "R5 decoded stream", rc_err, 0);
    chk(n_fuse == 27, "R5 fuse bits read with truncation", n_fuse, 27);
    chk(addr_err == 0, "R4 fuse addresses", addr_err, 0);
    chk(busy_err == 0, "R1 busy through load", busy_err, 0);
    chk(cache_ok == 1'b1, "R7 cache valid with done", cache_ok, 1);
    @(negedge clk);
    chk(!done, "R1 done one cycle", done, 0);
  endtask

  task automatic t_replay(input string tag);
    run_load(-1, -1);
    chk(n_fuse == 0, {tag, " no fuse reads"}, n_fuse, 0);
    chk(rc_err == 0 && n_rc == L, {tag, " replayed signature"}, rc_err, 0);
    chk(n_cyc == WTOT + L, {tag, " load latency"}, n_cyc, WTOT + L);
    chk(wir_err == 0, "R2 R3 wrapper stream on replay", wir_err, 0);
  endtask

  task automatic t_busy_start();
    run_load(40, 150);
    chk(n_cyc == WTOT + L, "R10 latency with stray starts", n_cyc, WTOT + L);
    chk(n_wir == WTOT && wir_err == 0, "R10 wrapper stream kept", wir_err, 0);
    chk(n_done == 1, "R10 single done", n_done, 1);
    repeat (3) @(negedge clk);
    chk(!busy && !wir_shift && !done, "R10 no restart", {busy, wir_shift, done}, 0);
  endtask

  task automatic t_reset_clears();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cache_ok, "R7 reset clears cache flag", cache_ok, 0);
    run_load(-1, -1);
    chk(n_fuse == 27 && addr_err == 0, "R4 fuses reread after reset", n_fuse, 27);
    chk(rc_err == 0 && n_rc == L, "R6 signature after reset", rc_err, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < FD; i++) fuse_mem[i] = 1'b0;
    f_idx = 0; e_idx = 0;
    put_lit(8'b10110010);
    put_run(4'd15, 1'b1);
    put_run(4'd2, 1'b0);
    put_lit(8'b01101001);
    do_reset();
    t_fuse_load();
    t_replay("R8");
    t_replay("R9");
    t_busy_start();
    t_reset_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule